// File: doc/BRIEF.md
# Charge-Balancing Integrator Reset Controller

This block is the digital side of an integrator that never saturates. Two comparators watch the integrator output. One fires when the output reaches the positive threshold and the other fires when it reaches the negative threshold. For each firing, the block moves a signed whole-unit count by one step. It also steers a precharged capacitor onto the integrator input with the polarity that removes one unit of charge. The count holds the integer part of the running integral, and the analog residue stays on the integrator.

A charge removal is a timed sequence:

1. One cycle with every switch open.
2. The polarity pattern, held for a programmable number of cycles.
3. Another cycle with every switch open.
4. Return to the recharge pattern, which is also the idle and reset pattern.

The comparator flags are asynchronous. Each flag passes through a two-flop synchronizer before the sequencer sees it. A flag must be seen low before it can start another removal. A simultaneous firing of both flags is rejected and reported on a one-cycle error strobe.

Top module: `chg_bal_ctrl`

## Requirements
- R1: After reset, the switch vector is 5'b00011 (switches 0 and 1 closed, recharge). The count is 0, and busy and error are low.
- R2: An upper-flag event drives the switch vector to 5'b01010 (odd switches 1 and 3). In the same cycle the count rises by one.
- R3: A lower-flag event drives the switch vector to 5'b10101 (even switches 0, 2 and 4). In the same cycle the count falls by one.
- R4: The polarity pattern is held for exactly T cycles, where T is the duration input. A value of 0 is treated as 1.
- R5: Exactly one all-open cycle (5'b00000) lies before and after the polarity pattern. Every change of the switch vector passes through all-open.
- R6: A flag that is high at a rising edge is accepted two edges later. Busy rises with acceptance and stays high through the trailing all-open cycle. Busy is low exactly when the recharge pattern is driven.
- R7: A flag held high for longer than a whole sequence produces only one event. It produces no further event until it has been seen low.
- R8: If both flags are seen high together in idle, no charge is removed and the count does not change. The error output pulses high for one cycle, at the cycle an acceptance would have occurred.
- R9: The count saturates at its most positive and most negative values and never wraps.
- R10: A clear input held high at a rising edge makes the count 0 after that edge. Clear overrides a simultaneous count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 1 | Upper-threshold comparator flag, asynchronous |
| cmp_lo_i | input | 1 | Lower-threshold comparator flag, asynchronous |
| dis_len_i | input | DUR_W | Discharge duration T in cycles; 0 means 1 |
| cnt_clr_i | input | 1 | Synchronous count clear |
| sw_o | output | 5 | Switch controls, bit n drives switch n |
| count_o | output | CNT_W | Signed whole-unit count |
| busy_o | output | 1 | A removal sequence is in progress |
| err_o | output | 1 | One-cycle strobe for a rejected simultaneous firing |

## Verification
The bench builds the block with a 6-bit count and a 4-bit duration. With the narrow count, both saturation limits (+31 and -32) are reached within a few hundred events, so the no-wrap behaviour is exercised at both ends. With the 4-bit duration, every discharge length from 0 to 15 can be swept for both polarities. The bench checks every cycle of each sequence against a timeline computed from the synchronizer depth and T. This includes a held flag, a simultaneous firing, and a clear landing on the exact edge of a count step.

// File: rtl/chg_bal_pkg.sv
package chg_bal_pkg;

    localparam int SW_N = 5;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_GAP_IN  = 2'd1,
        PH_DISCH   = 2'd2,
        PH_GAP_OUT = 2'd3
    } phase_e;

    function automatic logic [SW_N-1:0] parity_mask(input bit odd);
        logic [SW_N-1:0] m;
        m = '0;
        for (int i = 0; i < SW_N; i++) begin
            m[i] = ((i % 2) == 1) == odd;
        end
        return m;
    endfunction

    localparam logic [SW_N-1:0] SW_ODD   = parity_mask(1'b1);
    localparam logic [SW_N-1:0] SW_EVEN  = parity_mask(1'b0);
    localparam logic [SW_N-1:0] SW_RECHG = SW_N'(2'b11);
    localparam logic [SW_N-1:0] SW_OPEN  = '0;

endpackage

// File: rtl/chg_bal_sync.sv
module chg_bal_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = async_i;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_bal_cnt.sv
module chg_bal_cnt #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    inc_i,
    input  logic                    dec_i,
    output logic signed [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.val = '0;
        end else if (inc_i && !dec_i && (cnt_q.val != CNT_MAX)) begin
            cnt_d.val = cnt_q.val + CNT_W'(1);
        end else if (dec_i && !inc_i && (cnt_q.val != CNT_MIN)) begin
            cnt_d.val = cnt_q.val - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = $signed(cnt_q.val);
endmodule

// File: rtl/chg_bal_seq.sv
module chg_bal_seq
    import chg_bal_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_s_i,
    input  logic             lo_s_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic [SW_N-1:0]  sw_o,
    output logic             busy_o,
    output logic             err_o,
    output logic             step_up_o,
    output logic             step_dn_o
);
    typedef struct packed {
        phase_e          ph;
        logic [DUR_W-1:0] tmr;
        logic            pol;
        logic [1:0]      arm;
        logic [SW_N-1:0] sw;
        logic            busy;
        logic            err;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic    take_hi, take_lo, clash;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;

        take_hi = (seq_q.ph == PH_IDLE) && hi_s_i && seq_q.arm[0] && !lo_s_i;
        take_lo = (seq_q.ph == PH_IDLE) && lo_s_i && seq_q.arm[1] && !hi_s_i;
        clash   = (seq_q.ph == PH_IDLE) && hi_s_i && lo_s_i && (|seq_q.arm);

        unique case (seq_q.ph)
            PH_IDLE: begin
                if (clash) begin
                    seq_d.err = 1'b1;
                    seq_d.arm = 2'b00;
                end else if (take_hi || take_lo) begin
                    seq_d.ph  = PH_GAP_IN;
                    seq_d.pol = take_hi;
                    seq_d.tmr = (dur_i == '0) ? '0 : dur_i - DUR_W'(1);
                    if (take_hi) seq_d.arm[0] = 1'b0;
                    if (take_lo) seq_d.arm[1] = 1'b0;
                end
            end
            PH_GAP_IN:  seq_d.ph = PH_DISCH;
            PH_DISCH: begin
                if (seq_q.tmr == '0) seq_d.ph  = PH_GAP_OUT;
                else                 seq_d.tmr = seq_q.tmr - DUR_W'(1);
            end
            PH_GAP_OUT: seq_d.ph = PH_IDLE;
            default:    seq_d.ph = PH_IDLE;
        endcase

        if (!hi_s_i) seq_d.arm[0] = 1'b1;
        if (!lo_s_i) seq_d.arm[1] = 1'b1;

        unique case (seq_d.ph)
            PH_IDLE:  seq_d.sw = SW_RECHG;
            PH_DISCH: seq_d.sw = seq_d.pol ? SW_ODD : SW_EVEN;
            default:  seq_d.sw = SW_OPEN;
        endcase
        seq_d.busy = (seq_d.ph != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.ph   <= PH_IDLE;
            seq_q.arm  <= 2'b11;
            seq_q.sw   <= SW_RECHG;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sw_o      = seq_q.sw;
    assign busy_o    = seq_q.busy;
    assign err_o     = seq_q.err;
    assign step_up_o = (seq_q.ph == PH_GAP_IN) && seq_q.pol;
    assign step_dn_o = (seq_q.ph == PH_GAP_IN) && !seq_q.pol;
endmodule

// File: rtl/chg_bal_ctrl.sv
module chg_bal_ctrl
    import chg_bal_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DUR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_hi_i,
    input  logic                    cmp_lo_i,
    input  logic [DUR_W-1:0]        dis_len_i,
    input  logic                    cnt_clr_i,
    output logic [SW_N-1:0]         sw_o,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    busy_o,
    output logic                    err_o
);
    logic [1:0] flag_s;
    logic       step_up, step_dn;

    chg_bal_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmp_lo_i, cmp_hi_i}),
        .sync_o  (flag_s)
    );

    chg_bal_seq #(
        .DUR_W (DUR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_s_i    (flag_s[0]),
        .lo_s_i    (flag_s[1]),
        .dur_i     (dis_len_i),
        .sw_o      (sw_o),
        .busy_o    (busy_o),
        .err_o     (err_o),
        .step_up_o (step_up),
        .step_dn_o (step_dn)
    );

    chg_bal_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr_i),
        .inc_i (step_up),
        .dec_i (step_dn),
        .cnt_o (count_o)
    );
endmodule

// File: rtl/chg_bal_ctrl_chk.sv
module chg_bal_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic [4:0]              sw,
    input logic signed [CNT_W-1:0] cnt,
    input logic                    busy,
    input logic                    err
);
    localparam logic signed [CNT_W-1:0] C_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] C_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sw == 5'b00011) && !busy && !err);

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw == 5'b01010 && $past(sw) == 5'b00000 && !$past(clr) && $past(cnt) != C_MAX)
        |-> cnt == $past(cnt) + 1);

    p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw == 5'b10101 && $past(sw) == 5'b00000 && !$past(clr) && $past(cnt) != C_MIN)
        |-> cnt == $past(cnt) - 1);

    p_bbm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw != $past(sw)) |-> (sw == 5'b00000 || $past(sw) == 5'b00000));

    p_busy_rechg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (sw != 5'b00011));

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sw == 5'b00011) && !busy && $stable(cnt));

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_no_wrap_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == C_MAX && !$past(clr)) |-> cnt != C_MIN);

    p_no_wrap_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == C_MIN && !$past(clr)) |-> cnt != C_MAX);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> cnt == '0);

    p_count_only_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt) && !$past(clr)) |-> (sw == 5'b01010 || sw == 5'b10101));
endmodule

bind chg_bal_ctrl chg_bal_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr_i),
    .sw   (sw_o),
    .cnt  (count_o),
    .busy (busy_o),
    .err  (err_o)
);

// File: tb/chg_bal_ctrl_test.sv
`timescale 1ns/1ps
module chg_bal_ctrl_test;
    localparam int CW = 6;
    localparam int DW = 4;
    localparam int CMAX = 31;
    localparam int CMIN = -32;
    localparam logic [4:0] P_REC  = 5'b00011;
    localparam logic [4:0] P_ODD  = 5'b01010;
    localparam logic [4:0] P_EVEN = 5'b10101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, clr = 1'b0;
    logic [DW-1:0] len = '0;
    logic [4:0] sw;
    logic signed [CW-1:0] cnt;
    logic busy, err;

    int checks = 0;
    int errors = 0;
    int model = 0;

    always #2.5 clk = ~clk;

    chg_bal_ctrl #(.CNT_W(CW), .DUR_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_hi_i(hi), .cmp_lo_i(lo),
        .dis_len_i(len), .cnt_clr_i(clr),
        .sw_o(sw), .count_o(cnt), .busy_o(busy), .err_o(err)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > CMAX) return CMAX;
        if (v < CMIN) return CMIN;
        return v;
    endfunction

    // Samples are taken at falling edges; sample i follows rising edge k+i,
    // where edge k is the first to see the flags.
    task automatic run_event(input bit up, input bit dn, input int t, input int hold,
                             input int clr_at, input string tag);
        int te, last;
        bit ev, both;
        logic [4:0] pat, exp_sw;
        bit exp_busy, exp_err;
        te   = (t == 0) ? 1 : t;
        ev   = up ^ dn;
        both = up & dn;
        pat  = up ? P_ODD : P_EVEN;
        last = ((hold > 4 + te) ? hold : 4 + te) + 3;
        @(negedge clk);
        len = DW'(t);
        hi  = up;
        lo  = dn;
        clr = (clr_at == 0);
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            if (i == clr_at) model = 0;
            else if (ev && i == 3) model = sat(up ? model + 1 : model - 1);
            if (!ev || i < 2 || i >= 4 + te) begin
                exp_sw = P_REC; exp_busy = 1'b0;
            end else if (i == 2 || i == 3 + te) begin
                exp_sw = 5'b00000; exp_busy = 1'b1;
            end else begin
                exp_sw = pat; exp_busy = 1'b1;
            end
            exp_err = both && (i == 2);
            chk(sw == exp_sw, $sformatf("%s R4 R5 switches at sample %0d T=%0d", tag, i, t),
                int'(sw), int'(exp_sw));
            chk(busy == exp_busy, $sformatf("%s R6 busy at sample %0d", tag, i),
                int'(busy), int'(exp_busy));
            chk(err == exp_err, $sformatf("%s R8 error at sample %0d", tag, i),
                int'(err), int'(exp_err));
            chk(int'(cnt) == model, $sformatf("%s R9 R10 count at sample %0d", tag, i),
                int'(cnt), model);
            if (i == hold - 1) begin
                hi = 1'b0;
                lo = 1'b0;
            end
            clr = (i == clr_at - 1);
        end
        hi = 1'b0;
        lo = 1'b0;
        clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sw == P_REC, "R1 switches after reset", int'(sw), int'(P_REC));
        chk(int'(cnt) == 0, "R1 count after reset", int'(cnt), 0);
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(!err, "R1 error after reset", int'(err), 0);

        // R2 R3 R4: every duration for both polarities
        for (int t = 0; t < 16; t++) begin
            run_event(1'b1, 1'b0, t, 1, -1, "R2 upper");
            run_event(1'b0, 1'b1, t, 1, -1, "R3 lower");
        end

        // R7: held flags give one event each
        run_event(1'b1, 1'b0, 3, 25, -1, "R7 held upper");
        run_event(1'b0, 1'b1, 2, 25, -1, "R7 held lower");

        // R8: simultaneous firing
        run_event(1'b1, 1'b1, 2, 1, -1, "R8 both short");
        run_event(1'b1, 1'b1, 2, 10, -1, "R8 both held");

        // R10: clear in idle, clear on the step edge
        run_event(1'b1, 1'b0, 1, 1, -1, "R2 before clear");
        run_event(1'b0, 1'b0, 1, 1, 1, "R10 idle clear");
        run_event(1'b1, 1'b0, 2, 1, 3, "R10 clear on step");
        run_event(1'b0, 1'b1, 2, 1, 1, "R10 clear before step");

        // R9: saturate both ends
        for (int n = 0; n < 40; n++) run_event(1'b1, 1'b0, 1, 1, -1, "R9 upper sweep");
        chk(int'(cnt) == CMAX, "R9 upper limit", int'(cnt), CMAX);
        for (int n = 0; n < 70; n++) run_event(1'b0, 1'b1, 1, 1, -1, "R9 lower sweep");
        chk(int'(cnt) == CMIN, "R9 lower limit", int'(cnt), CMIN);
        run_event(1'b1, 1'b0, 1, 1, -1, "R9 leave lower limit");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule